// File: doc/BRIEF.md
# Operating-Range Residency Evaluator

This block scores how a thermal controller has behaved over an observation window. During an open window, each sample strobe delivers a core temperature in whole degrees Celsius and a core frequency level. The temperature is sorted into one of three bands and the frequency level into one of four bands. A counter per band, plus a total sample counter, records how long the core stayed in each band.

When the window closes, the block compares the actual residency of each band with a programmed target percentage. It computes the ratio of actual to target for all seven bands, one after another, on a single shared sequential divider. It then averages the ratios of each parameter into a per-parameter score. The overall index is the sum of the scores of the parameters that are enabled. A perfect controller scores 1.0 per parameter, and its index equals the number of enabled parameters.

All ratios, scores and the index are unsigned fixed point with 8 fractional bits, so 256 means 1.0. A one-cycle completion pulse marks the point where every result is valid.

Top module: `residency_eval`

## Requirements
- R1: After synchronous active-low reset, `done` is low and every ratio, both scores and the index read zero.
- R2: Temperature bands are coded 0=High, 1=Medium, 2=Low. A code above 78 is High, a code below 72 is Low, and every code from 72 to 78 inclusive is Medium.
- R3: Frequency bands follow `freq_lvl` directly: 0=Max, 1=High, 2=Medium, 3=Low.
- R4: A sample is counted only when `smp_valid` is high while the window is open. A sample in the cycle that asserts `win_start` is not counted. A sample in the cycle that asserts `win_end` is counted. Samples taken while the window is closed are ignored.
- R5: Each ratio equals floor(count × 25600 / (total × target)), a 16-bit value with 8 fractional bits. Band j of `ratio_freq` sits at bits [16j+15:16j], with j following the R3 code. Band k of `ratio_temp` sits at bits [16k+15:16k], with k following the R2 code.
- R6: A ratio whose target is 0 %, or any ratio of a window that holds no samples, saturates to 0xFFFF.
- R7: `score_freq` is floor(sum of the four frequency ratios / 4). `score_temp` is floor(sum of the three temperature ratios / 3).
- R8: `eval_index` is the sum of the scores of the enabled parameters. Bit 0 of `param_en` enables frequency and bit 1 enables temperature. A disabled parameter contributes 0.
- R9: `done` pulses high for exactly one cycle once all ratios, scores and the index are valid. These results hold until the next evaluation completes.
- R10: `win_start` clears all counters and opens a new window in any state. If a computation is in progress, it is abandoned and gives no `done`.
- R11: Targets are packed 7 bits per band in code order (`des_freq` band j at [7j+6:7j], `des_temp` band k at [7k+6:7k]). The targets and `param_en` are captured in the `win_end` cycle, and later changes do not affect the result being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_start | input | 1 | Clears counters and opens a window |
| win_end | input | 1 | Closes the open window and starts evaluation |
| smp_valid | input | 1 | Sample strobe |
| temp_c | input | 8 | Temperature sample in degrees Celsius |
| freq_lvl | input | 2 | Frequency band code of the sample |
| des_freq | input | 28 | Target percentages of the four frequency bands |
| des_temp | input | 21 | Target percentages of the three temperature bands |
| param_en | input | 2 | Parameter enables for the index |
| ratio_freq | output | 64 | Four frequency ratios, Q8.8 |
| ratio_temp | output | 48 | Three temperature ratios, Q8.8 |
| score_freq | output | 16 | Frequency score, Q8.8 |
| score_temp | output | 16 | Temperature score, Q8.8 |
| eval_index | output | 17 | Overall index, Q9.8 |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The assertions rely on a few properties of the inputs:
- Every `freq_lvl` code is a valid band.
- A nonzero target is at least 1 %. Together with a band count that can never exceed the total, this bounds every ratio at 25600.
- Windows are shorter than the 16-bit counter range.

The stimulus drives inputs on falling edges and keeps every window to a few dozen samples. Targets range from 0 to 100 %. The bench opens windows only through `win_start` and reads results only after the `done` pulse, apart from the cycles in which it checks that an abandoned computation stays silent.

// File: rtl/residency_pkg.sv
// Shared constants and types for the residency evaluator.
// Assumes two scored parameters: frequency (4 bands) and temperature (3 bands).
package residency_pkg;

    localparam int F_BANDS = 4;
    localparam int T_BANDS = 3;
    localparam int N_BANDS = F_BANDS + T_BANDS;

    typedef enum logic [1:0] {
        TB_HIGH = 2'd0,
        TB_MED  = 2'd1,
        TB_LOW  = 2'd2
    } tband_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } eval_state_e;

endpackage

// File: rtl/res_temp_class.sv
// Sorts a temperature code into High / Medium / Low.
// Assumes LO_LIMIT <= HI_LIMIT; codes in [LO_LIMIT, HI_LIMIT] are Medium.
module res_temp_class
    import residency_pkg::*;
#(
    parameter int TEMP_W   = 8,
    parameter int HI_LIMIT = 78,
    parameter int LO_LIMIT = 72
) (
    input  logic [TEMP_W-1:0] temp,
    output tband_e            band
);

    // purpose: strict comparisons at both limits, Medium otherwise
    always_comb begin
        if (temp > TEMP_W'(HI_LIMIT))
            band = TB_HIGH;
        else if (temp < TEMP_W'(LO_LIMIT))
            band = TB_LOW;
        else
            band = TB_MED;
    end

endmodule

// File: rtl/res_count_bank.sv
// Bank of NB residency counters; one counter advances per accepted sample.
// Assumes the caller stops inc before any counter could wrap.
module res_count_bank #(
    parameter int NB    = 4,
    parameter int CW    = 16,
    localparam int SW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 inc,
    input  logic [SW-1:0]        sel,
    output logic [NB-1:0][CW-1:0] cnt
);

    for (genvar g = 0; g < NB; g++) begin : g_cnt
        // purpose: clear on window open, count samples landing in band g
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt[g] <= '0;
            else if (inc && (sel == SW'(g)))
                cnt[g] <= cnt[g] + 1'b1;
        end
    end

endmodule

// File: rtl/res_seq_div.sv
// Restoring unsigned divider, one quotient bit per cycle, NUM_W cycles.
// Assumes den != 0 at start; start reloads and abandons any run in flight.
module res_seq_div #(
    parameter int NUM_W = 31,
    parameter int DEN_W = 23,
    localparam int LW   = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);

    logic [NUM_W-1:0] work;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem;
    logic [LW-1:0]    left;
    logic             busy;
    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W-1:0] diff;

    // purpose: next partial remainder and trial subtraction
    always_comb begin
        trial = {rem, work[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
        diff  = trial[DEN_W-1:0] - den_q;
    end

    // purpose: load on start, then shift in one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work  <= '0;
            num_q <= '0;
            den_q <= '0;
            rem   <= '0;
            left  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                work  <= num;
                num_q <= num;
                den_q <= den;
                rem   <= '0;
                left  <= LW'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem  <= fits ? diff : trial[DEN_W-1:0];
                work <= {work[NUM_W-2:0], fits};
                left <= left - 1'b1;
                if (left == LW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = work;

    // R5: quotient and remainder reconstruct the dividend exactly
    p_div_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (64'(work) * 64'(den_q) + 64'(rem) == 64'(num_q)));

    // R5: remainder stays below the divisor
    p_div_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < den_q));

endmodule

// File: rtl/residency_eval.sv
// Residency evaluator: counts per-band samples over a window, then computes
// actual/target ratios, per-parameter mean scores and a summed index.
// Assumes targets in percent; one shared divider serves all seven ratios.
module residency_eval
    import residency_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TEMP_W   = 8,
    parameter int PCT_W    = 7,
    parameter int RATIO_W  = 16,
    parameter int FRAC_W   = 8,
    parameter int HI_LIMIT = 78,
    parameter int LO_LIMIT = 72
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       win_start,
    input  logic                       win_end,
    input  logic                       smp_valid,
    input  logic [TEMP_W-1:0]          temp_c,
    input  logic [1:0]                 freq_lvl,
    input  logic [F_BANDS*PCT_W-1:0]   des_freq,
    input  logic [T_BANDS*PCT_W-1:0]   des_temp,
    input  logic [1:0]                 param_en,
    output logic [F_BANDS*RATIO_W-1:0] ratio_freq,
    output logic [T_BANDS*RATIO_W-1:0] ratio_temp,
    output logic [RATIO_W-1:0]         score_freq,
    output logic [RATIO_W-1:0]         score_temp,
    output logic [RATIO_W:0]           eval_index,
    output logic                       done
);

    localparam int PCT_SCALE = 100 << FRAC_W;
    localparam int NUM_W     = CNT_W + $clog2(PCT_SCALE + 1);
    localparam int DEN_W     = CNT_W + PCT_W;
    localparam int IDX_W     = $clog2(N_BANDS);
    localparam int SUM_W     = RATIO_W + 2;
    localparam int IX_W      = RATIO_W + 1;
    localparam logic [RATIO_W-1:0] SAT = '1;

    eval_state_e                       state;
    logic [IDX_W-1:0]                  idx;
    logic [CNT_W-1:0]                  total;
    logic                              cnt_en;
    tband_e                            tband;
    logic [F_BANDS-1:0][CNT_W-1:0]     fcnt;
    logic [T_BANDS-1:0][CNT_W-1:0]     tcnt;
    logic [N_BANDS-1:0][CNT_W-1:0]     all_cnt;
    logic [N_BANDS-1:0][PCT_W-1:0]     des_q;
    logic [1:0]                        en_q;
    logic [N_BANDS-1:0][RATIO_W-1:0]   ratio_q;
    logic [CNT_W-1:0]                  sel_cnt;
    logic [PCT_W-1:0]                  sel_des;
    logic [NUM_W-1:0]                  div_num;
    logic [DEN_W-1:0]                  div_den;
    logic                              div_start;
    logic                              div_done;
    logic [NUM_W-1:0]                  div_quo;
    logic [RATIO_W-1:0]                quo_sat;
    logic [SUM_W-1:0]                  sum_f;
    logic [SUM_W-1:0]                  sum_t;
    logic [RATIO_W-1:0]                score_f_n;
    logic [RATIO_W-1:0]                score_t_n;
    logic [CNT_W+1:0]                  fsum_cnt;
    logic [CNT_W+1:0]                  tsum_cnt;

    res_temp_class #(
        .TEMP_W  (TEMP_W),
        .HI_LIMIT(HI_LIMIT),
        .LO_LIMIT(LO_LIMIT)
    ) u_class (
        .temp(temp_c),
        .band(tband)
    );

    // purpose: accept a sample only inside an open window with headroom
    assign cnt_en = (state == ST_OPEN) && smp_valid && !win_start && (total != '1);

    res_count_bank #(.NB(F_BANDS), .CW(CNT_W)) u_fbank (
        .clk(clk), .rst_n(rst_n), .clr(win_start), .inc(cnt_en),
        .sel(freq_lvl), .cnt(fcnt)
    );

    res_count_bank #(.NB(T_BANDS), .CW(CNT_W)) u_tbank (
        .clk(clk), .rst_n(rst_n), .clr(win_start), .inc(cnt_en),
        .sel(tband), .cnt(tcnt)
    );

    // purpose: total samples accepted in the current window
    always_ff @(posedge clk) begin
        if (!rst_n || win_start)
            total <= '0;
        else if (cnt_en)
            total <= total + 1'b1;
    end

    // purpose: flatten both banks into ratio order (frequency first)
    always_comb begin
        for (int k = 0; k < F_BANDS; k++) all_cnt[k] = fcnt[k];
        for (int k = 0; k < T_BANDS; k++) all_cnt[F_BANDS+k] = tcnt[k];
    end

    // purpose: operands of the ratio currently being computed
    always_comb begin
        sel_cnt = all_cnt[idx];
        sel_des = des_q[idx];
        div_num = NUM_W'(sel_cnt) * NUM_W'(PCT_SCALE);
        div_den = DEN_W'(total) * DEN_W'(sel_des);
        div_start = (state == ST_ISSUE) && (div_den != '0);
        quo_sat = (|div_quo[NUM_W-1:RATIO_W]) ? SAT : div_quo[RATIO_W-1:0];
    end

    res_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
    );

    // purpose: per-parameter means and the enabled-sum index
    always_comb begin
        sum_f = '0;
        sum_t = '0;
        for (int k = 0; k < F_BANDS; k++) sum_f = sum_f + SUM_W'(ratio_q[k]);
        for (int k = 0; k < T_BANDS; k++) sum_t = sum_t + SUM_W'(ratio_q[F_BANDS+k]);
        score_f_n = RATIO_W'(sum_f / SUM_W'(F_BANDS));
        score_t_n = RATIO_W'(sum_t / SUM_W'(T_BANDS));
    end

    // purpose: window control and the seven-step ratio sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            des_q      <= '0;
            en_q       <= '0;
            ratio_q    <= '0;
            score_freq <= '0;
            score_temp <= '0;
            eval_index <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (win_start) begin
                state <= ST_OPEN;
            end else begin
                case (state)
                    ST_OPEN: if (win_end) begin
                        for (int k = 0; k < F_BANDS; k++)
                            des_q[k] <= des_freq[k*PCT_W +: PCT_W];
                        for (int k = 0; k < T_BANDS; k++)
                            des_q[F_BANDS+k] <= des_temp[k*PCT_W +: PCT_W];
                        en_q  <= param_en;
                        idx   <= '0;
                        state <= ST_ISSUE;
                    end
                    ST_ISSUE: if (div_den == '0) begin
                        ratio_q[idx] <= SAT;
                        state <= (idx == IDX_W'(N_BANDS-1)) ? ST_FIN : ST_ISSUE;
                        idx   <= idx + 1'b1;
                    end else begin
                        state <= ST_WAIT;
                    end
                    ST_WAIT: if (div_done) begin
                        ratio_q[idx] <= quo_sat;
                        state <= (idx == IDX_W'(N_BANDS-1)) ? ST_FIN : ST_ISSUE;
                        idx   <= idx + 1'b1;
                    end
                    ST_FIN: begin
                        score_freq <= score_f_n;
                        score_temp <= score_t_n;
                        eval_index <= (en_q[0] ? IX_W'(score_f_n) : '0)
                                    + (en_q[1] ? IX_W'(score_t_n) : '0);
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // purpose: drive the packed result ports
    always_comb begin
        for (int k = 0; k < F_BANDS; k++)
            ratio_freq[k*RATIO_W +: RATIO_W] = ratio_q[k];
        for (int k = 0; k < T_BANDS; k++)
            ratio_temp[k*RATIO_W +: RATIO_W] = ratio_q[F_BANDS+k];
    end

    // purpose: band sums for the residency consistency check
    always_comb begin
        fsum_cnt = '0;
        tsum_cnt = '0;
        for (int k = 0; k < F_BANDS; k++) fsum_cnt = fsum_cnt + (CNT_W+2)'(fcnt[k]);
        for (int k = 0; k < T_BANDS; k++) tsum_cnt = tsum_cnt + (CNT_W+2)'(tcnt[k]);
    end

    // R4: every accepted sample lands in exactly one band of each parameter
    p_band_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsum_cnt == (CNT_W+2)'(total)) && (tsum_cnt == (CNT_W+2)'(total)));

    // R4: nothing is counted while the window is closed
    p_closed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OPEN && !win_start) |=> $stable(total));

    // R5: with a nonzero target a ratio never exceeds 100 % / 1 %
    p_ratio_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && div_done) |-> (div_quo <= NUM_W'(PCT_SCALE)));

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a window open request always lands in the open state
    p_start_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> (state == ST_OPEN && total == '0));

endmodule

// File: tb/residency_eval_tb.sv
module residency_eval_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_start = 1'b0, win_end = 1'b0, smp_valid = 1'b0;
    logic [7:0]  temp_c = '0;
    logic [1:0]  freq_lvl = '0;
    logic [27:0] des_freq = '0;
    logic [20:0] des_temp = '0;
    logic [1:0]  param_en = '0;
    logic [63:0] ratio_freq;
    logic [47:0] ratio_temp;
    logic [15:0] score_freq, score_temp;
    logic [16:0] eval_index;
    logic        done;

    int n_chk = 0, n_bad = 0;
    longint cf[4], ct[3], tot;
    longint m_df[4], m_dt[3];
    logic [1:0] m_en;

    always #10 clk = ~clk;

    residency_eval u_dut (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
        .smp_valid(smp_valid), .temp_c(temp_c), .freq_lvl(freq_lvl),
        .des_freq(des_freq), .des_temp(des_temp), .param_en(param_en),
        .ratio_freq(ratio_freq), .ratio_temp(ratio_temp),
        .score_freq(score_freq), .score_temp(score_temp),
        .eval_index(eval_index), .done(done)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint eratio(longint c, longint t, longint d);
        if (d == 0 || t == 0) return 65535;
        return (c * 25600) / (t * d);
    endfunction

    function automatic int tband(int t);
        if (t > 78) return 0;
        if (t < 72) return 2;
        return 1;
    endfunction

    task automatic set_des(int f0, int f1, int f2, int f3, int t0, int t1, int t2, int en);
        des_freq = {7'(f3), 7'(f2), 7'(f1), 7'(f0)};
        des_temp = {7'(t2), 7'(t1), 7'(t0)};
        param_en = 2'(en);
    endtask

    task automatic count(int t, int f);
        cf[f]++;
        ct[tband(t)]++;
        tot++;
    endtask

    task automatic start_win(bit with_smp);
        @(negedge clk);
        win_start = 1'b1; smp_valid = with_smp; temp_c = 8'd90; freq_lvl = 2'd0;
        @(negedge clk);
        win_start = 1'b0; smp_valid = 1'b0;
        for (int k = 0; k < 4; k++) cf[k] = 0;
        for (int k = 0; k < 3; k++) ct[k] = 0;
        tot = 0;
    endtask

    task automatic samp(int t, int f, bit counted);
        @(negedge clk);
        smp_valid = 1'b1; temp_c = 8'(t); freq_lvl = 2'(f);
        if (counted) count(t, f);
    endtask

    task automatic end_win(bit with_smp, int t, int f);
        @(negedge clk);
        win_end = 1'b1; smp_valid = with_smp; temp_c = 8'(t); freq_lvl = 2'(f);
        if (with_smp) count(t, f);
        for (int k = 0; k < 4; k++) m_df[k] = longint'(des_freq[7*k +: 7]);
        for (int k = 0; k < 3; k++) m_dt[k] = longint'(des_temp[7*k +: 7]);
        m_en = param_en;
        @(negedge clk);
        win_end = 1'b0; smp_valid = 1'b0;
    endtask

    task automatic wait_done();
        bit got = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
        chk("R9 done seen", got, 1);
    endtask

    task automatic check_results();
        longint sf = 0, st = 0, r;
        for (int j = 0; j < 4; j++) begin
            r = eratio(cf[j], tot, m_df[j]);
            sf += r;
            chk((m_df[j] == 0 || tot == 0) ? "R6 freq ratio" : "R5 freq ratio",
                longint'(ratio_freq[16*j +: 16]), r);
        end
        for (int k = 0; k < 3; k++) begin
            r = eratio(ct[k], tot, m_dt[k]);
            st += r;
            chk((m_dt[k] == 0 || tot == 0) ? "R6 temp ratio" : "R5 temp ratio",
                longint'(ratio_temp[16*k +: 16]), r);
        end
        sf = sf / 4;
        st = st / 3;
        chk("R7 score_freq", longint'(score_freq), sf);
        chk("R7 score_temp", longint'(score_temp), st);
        chk("R8 index", longint'(eval_index), (m_en[0] ? sf : 0) + (m_en[1] ? st : 0));
        @(negedge clk);
        chk("R9 done one cycle", longint'(done), 0);
    endtask

    // R1: outputs after reset
    task automatic t_reset();
        chk("R1 done", longint'(done), 0);
        chk("R1 ratio_freq", longint'(ratio_freq != 0), 0);
        chk("R1 ratio_temp", longint'(ratio_temp != 0), 0);
        chk("R1 scores", longint'(score_freq) + longint'(score_temp), 0);
        chk("R1 index", longint'(eval_index), 0);
    endtask

    // R3 R5 R7 R8: uniform medium temperature, high frequency
    task automatic t_example();
        set_des(20, 50, 20, 10, 30, 40, 30, 3);
        start_win(0);
        for (int i = 0; i < 10; i++) samp(76, 1, 1);
        end_win(0, 0, 0);
        wait_done();
        chk("R5 temp medium 2.5", longint'(ratio_temp[31:16]), 640);
        chk("R5 freq high 2.0", longint'(ratio_freq[31:16]), 512);
        chk("R7 score_temp 0.83", longint'(score_temp), 213);
        chk("R8 index sum", longint'(eval_index), 341);
        check_results();
    endtask

    // R2 R3: temperature limits and every frequency code
    task automatic t_bounds();
        int tl[8] = '{79, 78, 74, 73, 72, 71, 0, 255};
        int fl[8] = '{0, 0, 1, 2, 3, 3, 3, 1};
        set_des(25, 25, 25, 25, 25, 50, 25, 3);
        start_win(0);
        for (int i = 0; i < 8; i++) samp(tl[i], fl[i], 1);
        end_win(0, 0, 0);
        wait_done();
        chk("R2 high band", longint'(ratio_temp[15:0]), 256);
        chk("R2 medium band incl 72..78", longint'(ratio_temp[31:16]), 256);
        chk("R2 low band", longint'(ratio_temp[47:32]), 256);
        chk("R3 medium freq", longint'(ratio_freq[47:32]), 128);
        chk("R3 low freq", longint'(ratio_freq[63:48]), 384);
        check_results();
    endtask

    // R4 R11: samples outside the window and late target changes
    task automatic t_window();
        set_des(10, 20, 30, 40, 20, 20, 60, 2);
        for (int i = 0; i < 3; i++) samp(90, 0, 0);
        start_win(1);
        for (int i = 0; i < 4; i++) samp(60, 2, 1);
        end_win(1, 60, 2);
        set_des(1, 1, 1, 1, 1, 1, 1, 3);
        for (int i = 0; i < 5; i++) samp(95, 0, 0);
        @(negedge clk);
        smp_valid = 1'b0;
        wait_done();
        chk("R4 samples only in window", longint'(ratio_temp[15:0]), 0);
        chk("R4 end-cycle sample counted", longint'(ratio_freq[47:32]), 853);
        chk("R11 captured target", longint'(ratio_temp[47:32]), 426);
        chk("R11 captured enable", longint'(eval_index), longint'(score_temp));
        check_results();
    endtask

    // R6: zero target and empty window saturate
    task automatic t_zero();
        set_des(0, 30, 30, 40, 30, 40, 30, 1);
        start_win(0);
        for (int i = 0; i < 4; i++) samp(80 - 4 * i, i, 1);
        end_win(0, 0, 0);
        wait_done();
        chk("R6 zero target", longint'(ratio_freq[15:0]), 65535);
        check_results();
        set_des(20, 50, 20, 10, 30, 40, 30, 3);
        start_win(0);
        end_win(0, 0, 0);
        wait_done();
        chk("R6 empty window", longint'(ratio_temp[31:16]), 65535);
        check_results();
    endtask

    // R10: a new window abandons the computation in flight
    task automatic t_abort();
        bit seen = 0;
        set_des(25, 25, 25, 25, 30, 40, 30, 3);
        start_win(0);
        for (int i = 0; i < 5; i++) samp(80, 0, 1);
        end_win(0, 0, 0);
        repeat (30) @(negedge clk);
        start_win(0);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk("R10 no done after abort", seen, 0);
        for (int i = 0; i < 3; i++) samp(70, 3, 1);
        end_win(0, 0, 0);
        wait_done();
        chk("R10 counters cleared", longint'(ratio_temp[15:0]), 0);
        check_results();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_bounds();
        t_window();
        t_zero();
        t_abort();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule